// File: doc/BRIEF.md
# Multi-Step Rotating Galois Sequence Generator

This block produces a pseudo-random sequence from a linear feedback shift register of Galois form. Each clock it advances the register by a configurable number of single steps. The advance is built as an unrolled combinational chain of identical step stages between the register output and its input.

One step works as follows. The register is rotated right by one place, so the old bit 0 wraps into the top bit. If that wrapped bit is 1, the lower `WIDTH-1` bits of the polynomial are XORed into the rotated value. The top bit of the polynomial is always 1. It stands for the wrap path itself, so it costs no XOR gate. A polynomial whose bit 0 is clear passes the old bit 1 into bit 0 without a gate.

Width, polynomial and steps per clock are parameters. The default is 32 bits with the dense polynomial 0xFFFFFFFA, which puts 29 XOR taps in a row. Two other configurations are supported:
- 8 bits with polynomial 0xFA, six steps per clock.
- 5 bits with polynomial 0x1E, one step per clock.

A seed can be loaded at any time. A seed of zero is replaced by 1, because an all-zero register would never leave zero.

Top module: `galois_multistep_lfsr`

## Requirements
- R1: One step maps state `s` to `r ^ (s[0] ? POLY[WIDTH-2:0] : 0)`, where `r = {s[0], s[WIDTH-1:1]}` is the right rotation. `POLY[WIDTH-1]` is 1 and only marks the wrap.
- R2: With `en` high and `load` low, the state after a rising clock edge equals the single step of R1 applied `STEPS` times to the previous state.
- R3: With `en` and `load` both low, the state keeps its value across the clock edge.
- R4: `load` takes priority over `en`. A nonzero `seed` presented with `load` high appears on `state` after the next rising edge.
- R5: A `load` with `seed` equal to zero puts the value 1 into the state.
- R6: While `rst_n` is low, `state` is `INIT`, which is 1 by default. The reset is asynchronous.
- R7: Out of reset, `state` is never zero.
- R8: With 8 bits, polynomial 0xFA and six steps per clock, the clocked sequence from any nonzero start returns to that start after exactly 85 clocks and not before. This is 510 steps, twice the 255-step cycle. It cannot happen sooner because gcd(6, 255) = 3.
- R9: With 5 bits, polynomial 0x1E and one step per clock, the sequence returns to its start after exactly 31 clocks and not before.
- R10: The default configuration (32 bits, 0xFFFFFFFA, four steps per clock) follows R2 for any loaded seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the register by `STEPS` steps this clock |
| load | input | 1 | Load `seed` this clock (overrides `en`) |
| seed | input | WIDTH | Seed value; zero is replaced by 1 |
| state | output | WIDTH | Current register contents |

## Verification
The assertions watch four things on every clock:
- the register is never zero;
- it holds when idle;
- a nonzero load lands exactly;
- a zero load lands as 1.

Whether the unrolled chain computes the right step function cannot be seen from one cycle in isolation. The bench shows it by comparing every clock against an iterated software step, for all three polynomial configurations. The cycle lengths of the 8-bit and 5-bit configurations are global properties of the sequence. Only the bench's long runs can demonstrate them, by counting clocks until the start value reappears.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  localparam int unsigned DEF_WIDTH = 32;
  localparam logic [31:0] DEF_POLY  = 32'hFFFF_FFFA;
  localparam int unsigned DEF_STEPS = 4;

  // Value that replaces a forbidden all-zero seed
  function automatic logic [DEF_WIDTH-1:0] lockup_escape();
    return DEF_WIDTH'(1);
  endfunction

endpackage

// File: rtl/lfsr_rot_step.sv
// One Galois step: rotate right, then fold the wrapped bit into the
// tap positions named by the polynomial's lower bits.
module lfsr_rot_step #(
  parameter int unsigned           WIDTH = 32,
  parameter logic [WIDTH-1:0]      POLY  = '1
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  logic             wrap_bit;
  logic [WIDTH-1:0] rotated;

  assign wrap_bit = cur[0];
  assign rotated  = {cur[0], cur[WIDTH-1:1]};

  // Top bit is the wrap link only: no gate there
  assign nxt[WIDTH-1] = rotated[WIDTH-1];

  for (genvar b = 0; b < WIDTH - 1; b++) begin : g_tap
    if (POLY[b]) begin : g_xor
      assign nxt[b] = rotated[b] ^ wrap_bit;
    end else begin : g_pass
      assign nxt[b] = rotated[b];
    end
  end

endmodule

// File: rtl/lfsr_unroll.sv
// Chain of STEPS single-step stages, purely combinational.
module lfsr_unroll #(
  parameter int unsigned      WIDTH = 32,
  parameter logic [WIDTH-1:0] POLY  = '1,
  parameter int unsigned      STEPS = 4
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned NODES = STEPS + 1;

  logic [WIDTH-1:0] node [NODES];

  assign node[0] = din;

  for (genvar k = 0; k < STEPS; k++) begin : g_stage
    lfsr_rot_step #(
      .WIDTH (WIDTH),
      .POLY  (POLY)
    ) u_step (
      .cur (node[k]),
      .nxt (node[k+1])
    );
  end

  assign dout = node[STEPS];

endmodule

// File: rtl/lfsr_seed_guard.sv
// Replaces an all-zero seed by 1 so the register cannot lock up.
module lfsr_seed_guard #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] safe
);

  localparam logic [WIDTH-1:0] ESCAPE = WIDTH'(1);

  logic is_zero;

  assign is_zero = (raw == '0);
  assign safe    = is_zero ? ESCAPE : raw;

endmodule

// File: rtl/galois_multistep_lfsr.sv
module galois_multistep_lfsr
  import lfsr_pkg::*;
#(
  parameter int unsigned      WIDTH = DEF_WIDTH,
  parameter logic [WIDTH-1:0] POLY  = WIDTH'(DEF_POLY),
  parameter int unsigned      STEPS = DEF_STEPS,
  parameter logic [WIDTH-1:0] INIT  = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] advanced;
  logic [WIDTH-1:0] seed_safe;
  logic             upd_en;

  lfsr_unroll #(
    .WIDTH (WIDTH),
    .POLY  (POLY),
    .STEPS (STEPS)
  ) u_unroll (
    .din  (state_q),
    .dout (advanced)
  );

  lfsr_seed_guard #(
    .WIDTH (WIDTH)
  ) u_guard (
    .raw  (seed),
    .safe (seed_safe)
  );

  // Next-state selection: load wins over advance
  assign upd_en = load | en;

  always_comb begin
    state_d = state_q;
    if (load) begin
      state_d = seed_safe;
    end else if (en) begin
      state_d = advanced;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= INIT;
    end else if (upd_en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R7: register never reaches the lock-up value
  assert_no_zero_state_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    state_q != '0
  ) else $error("state reached zero");

  // R3: idle cycles keep the value
  assert_idle_hold_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> $stable(state_q)
  ) else $error("state moved while idle");

  // R4: nonzero seed lands on the next edge, regardless of en
  assert_load_lands_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> (state_q == $past(seed))
  ) else $error("loaded seed not taken");

  // R5: zero seed is replaced by one
  assert_zero_seed_escape_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (load && seed == '0) |=> (state_q == ONE)
  ) else $error("zero seed not escaped");

endmodule

// File: tb/tb_galois_multistep_lfsr.sv
module tb_galois_multistep_lfsr;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        load;
  logic [31:0] seed32;
  logic [7:0]  seed8;
  logic [4:0]  seed5;
  logic [31:0] st32;
  logic [7:0]  st8;
  logic [4:0]  st5;

  int n_checks = 0;
  int n_errs   = 0;

  always #5 clk = ~clk;

  galois_multistep_lfsr dut (
    .clk (clk), .rst_n (rst_n), .en (en), .load (load),
    .seed (seed32), .state (st32)
  );

  galois_multistep_lfsr #(.WIDTH(8), .POLY(8'hFA), .STEPS(6)) dut8 (
    .clk (clk), .rst_n (rst_n), .en (en), .load (load),
    .seed (seed8), .state (st8)
  );

  galois_multistep_lfsr #(.WIDTH(5), .POLY(5'h1E), .STEPS(1)) dut5 (
    .clk (clk), .rst_n (rst_n), .en (en), .load (load),
    .seed (seed5), .state (st5)
  );

  // Software model: shift right, fold full polynomial in when bit 0 set
  function automatic logic [31:0] m_step(input logic [31:0] s, input int w,
                                         input logic [31:0] poly);
    logic [31:0] mask;
    logic [31:0] r;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    r = (s & mask) >> 1;
    if (s[0]) r = r ^ (poly & mask);
    return r & mask;
  endfunction

  function automatic logic [31:0] m_adv(input logic [31:0] s, input int w,
                                        input logic [31:0] poly, input int n);
    logic [31:0] v;
    v = s;
    for (int i = 0; i < n; i++) v = m_step(v, w, poly);
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; load = 1'b0;
    seed32 = '0; seed8 = '0; seed5 = '0;
    #23;
    check("R6 reset 32", st32, 32'h1);
    check("R6 reset 8", {24'h0, st8}, 32'h1);
    check("R6 reset 5", {27'h0, st5}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    cyc();
    check("R6 after release", {24'h0, st8}, 32'h1);
  endtask

  task automatic t_load_priority();
    seed8 = 8'h5A; seed32 = 32'h1234_5678; seed5 = 5'h0B;
    load = 1'b1; en = 1'b1;
    cyc();
    load = 1'b0; en = 1'b0;
    check("R4 load over en 8", {24'h0, st8}, 32'h5A);
    check("R4 load over en 32", st32, 32'h1234_5678);
    check("R4 load over en 5", {27'h0, st5}, 32'h0B);
  endtask

  task automatic t_zero_seed();
    seed8 = 8'h00; seed32 = 32'h0; seed5 = 5'h0;
    load = 1'b1;
    cyc();
    load = 1'b0;
    check("R5 zero seed 8", {24'h0, st8}, 32'h1);
    check("R5 zero seed 32", st32, 32'h1);
    check("R5 zero seed 5", {27'h0, st5}, 32'h1);
  endtask

  task automatic t_hold();
    seed8 = 8'hC3; load = 1'b1;
    cyc();
    load = 1'b0; en = 1'b0; seed8 = 8'h77;
    for (int i = 0; i < 4; i++) begin
      cyc();
      check("R3 hold 8", {24'h0, st8}, 32'hC3);
    end
  endtask

  task automatic t_advance8();
    logic [31:0] exp;
    seed8 = 8'h01; load = 1'b1;
    cyc();
    load = 1'b0; en = 1'b1;
    exp = 32'h01;
    // first step by hand: 0x01 rotates to 0x80, wrap folds 0x7A -> 0xFA
    check("R1 single step", m_step(32'h01, 8, 32'hFA), 32'hFA);
    for (int i = 0; i < 20; i++) begin
      cyc();
      exp = m_adv(exp, 8, 32'hFA, 6);
      check("R2 six steps 8", {24'h0, st8}, exp);
    end
    en = 1'b0;
  endtask

  task automatic t_period8();
    logic [7:0] start;
    seed8 = 8'h9D; load = 1'b1;
    cyc();
    load = 1'b0; en = 1'b1;
    start = st8;
    for (int k = 1; k < 85; k++) begin
      cyc();
      check("R8 no early repeat", {31'h0, st8 == start}, 32'h0);
      check("R7 nonzero 8", {31'h0, st8 == 8'h0}, 32'h0);
    end
    cyc();
    check("R8 period 85 clocks", {24'h0, st8}, {24'h0, start});
    en = 1'b0;
  endtask

  task automatic t_period5();
    logic [31:0] exp;
    seed5 = 5'h13; load = 1'b1;
    cyc();
    load = 1'b0; en = 1'b1;
    exp = 32'h13;
    for (int k = 1; k < 31; k++) begin
      cyc();
      exp = m_step(exp, 5, 32'h1E);
      check("R9 model 5", {27'h0, st5}, exp);
      check("R9 no early repeat", {31'h0, st5 == 5'h13}, 32'h0);
    end
    cyc();
    check("R9 period 31 clocks", {27'h0, st5}, 32'h13);
    en = 1'b0;
  endtask

  task automatic t_wide32();
    logic [31:0] exp;
    seed32 = 32'hDEAD_BEEF; load = 1'b1;
    cyc();
    load = 1'b0; en = 1'b1;
    exp = 32'hDEAD_BEEF;
    for (int i = 0; i < 50; i++) begin
      cyc();
      exp = m_adv(exp, 32, 32'hFFFF_FFFA, 4);
      check("R10 default 32", st32, exp);
      check("R7 nonzero 32", {31'h0, st32 == 32'h0}, 32'h0);
    end
    en = 1'b0;
    cyc();
    check("R3 hold 32", st32, exp);
  endtask

  initial begin
    #2_000_000;
    n_errs++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    t_reset();
    t_load_priority();
    t_zero_seed();
    t_hold();
    t_advance8();
    t_period8();
    t_period5();
    t_wide32();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule